// File: doc/BRIEF.md
# Level-Sensitive Interrupt Aggregator

This block gathers 32 level-sensitive interrupt request lines from peripherals and folds them onto two interrupt inputs of a CPU. Each line has a mask bit. Software turns mask bits on through one register address and off through a second address. At both addresses a bit written as 1 acts on its line and a bit written as 0 leaves that line alone. The top bit of the mask word is a master switch. While the master switch is clear, neither CPU line can rise. A routing word picks, for each line, which of the two CPU inputs the line drives.

Software reads one status word per CPU line. Each word is a bitmap of the sources that are pending, enabled and routed to that line, and software scans it from the lowest set bit. A separate word shows the synchronised input levels with no masking. The sources are levels, so a status bit stays set while its line is high and enabled. The only way to quiet a source from the controller's side is to mask it.

Register access is a single-cycle strobe with a write flag, a byte address and 32-bit data. Read data is valid in the same cycle as the strobe.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: After reset the mask word, the master switch and the routing word are all zero. Both CPU lines are low, and a read of offset 0x34 returns 0.
- R2: A write to offset 0x34 sets every mask bit whose data bit is 1 and leaves the others unchanged. A read of 0x34 or 0x38 returns the mask word, with bit 31 as the master switch.
- R3: A write to offset 0x38 clears every mask bit whose data bit is 1 and leaves the others unchanged. Writing 0xFFFFFFFF clears the whole word.
- R4: While mask bit 31 (the master switch) is 0, both CPU lines stay low whatever the sources, mask bits and routing are.
- R5: A read of offset 0x00 returns raw AND mask AND NOT route, with bit 31 forced to 0.
- R6: A read of offset 0x04 returns raw AND mask AND route, with bit 31 forced to 0. A route bit of 1 sends its source to CPU line 1, and a route bit of 0 sends it to line 0.
- R7: Each CPU line rises one clock after its status word becomes non-zero while the master switch is set, and falls one clock after either condition goes away.
- R8: A read of offset 0x30 returns the raw source levels, unmasked. A change on a source input shows there after exactly three rising clock edges (two synchroniser flops and the raw register).
- R9: A status bit stays set for as long as its source is high and enabled. Clearing its mask bit removes it from status, and so does lowering the source.
- R10: Reads of unmapped offsets return 0, and writes to them change neither the mask word nor the routing word.
- R11: A write to offset 0x20 loads the routing word, and a read of 0x20 returns it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the strobe cycle |
| src_irq | input | 32 | Level interrupt request lines, asynchronous |
| cpu_irq0 | output | 1 | Interrupt to CPU line 0 |
| cpu_irq1 | output | 1 | Interrupt to CPU line 1 |

## Verification
The routing logic is tried with a table of source, mask and route patterns. A single source on line 0 and a single source on line 1 show that the route bit is honoured. Two sources split across the lines show that both lines can be active at once. A full source bus with only the master switch set shows that the per-line mask bits really gate. Enabled sources with the master switch clear show that the switch gates the CPU lines. A lone bit-31 source shows that bit 31 is left out of both status words. Directed sequences then separate the set and clear write semantics from a plain overwrite, measure the synchroniser and output latency edge by edge, and hold a level across many cycles before it is released by masking or by lowering the source.

// File: rtl/lvl_irq_pkg.sv
package lvl_irq_pkg;
    parameter int unsigned NSRC  = 32;
    parameter int unsigned AW    = 8;
    localparam int unsigned GBIT = NSRC - 1;

    localparam logic [AW-1:0] OFS_ST0  = 8'h00;
    localparam logic [AW-1:0] OFS_ST1  = 8'h04;
    localparam logic [AW-1:0] OFS_TYPE = 8'h20;
    localparam logic [AW-1:0] OFS_RAW  = 8'h30;
    localparam logic [AW-1:0] OFS_SET  = 8'h34;
    localparam logic [AW-1:0] OFS_CLR  = 8'h38;

    typedef struct packed {
        logic [NSRC-1:0] en;
        logic [NSRC-1:0] route;
    } cfg_t;

    typedef struct packed {
        logic irq0;
        logic irq1;
    } outs_t;
endpackage

// File: rtl/lvl_irq_sync.sv
module lvl_irq_sync #(
    parameter int unsigned W      = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] raw_out
);
    localparam int unsigned DEPTH = STAGES + 1;

    logic [W-1:0] pipe_d [DEPTH];
    logic [W-1:0] pipe_q [DEPTH];

    always_comb begin
        pipe_d[0] = async_in;
        for (int i = 1; i < DEPTH; i++) begin
            pipe_d[i] = pipe_q[i-1];
        end
    end

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe_q[g] <= '0;
                else        pipe_q[g] <= pipe_d[g];
            end
        end
    endgenerate

    assign raw_out = pipe_q[DEPTH-1];

    assert_raw_lag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pipe_q[DEPTH-2] != raw_out |=> raw_out == $past(pipe_q[DEPTH-2]));
endmodule

// File: rtl/lvl_irq_regs.sv
module lvl_irq_regs
    import lvl_irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_sel,
    input  logic            bus_wr,
    input  logic [AW-1:0]   bus_addr,
    input  logic [NSRC-1:0] bus_wdata,
    input  logic [NSRC-1:0] raw,
    input  logic [NSRC-1:0] st0,
    input  logic [NSRC-1:0] st1,
    output cfg_t            cfg,
    output logic [NSRC-1:0] bus_rdata
);
    cfg_t cfg_d, cfg_q;
    logic wr_set, wr_clr, wr_type, wr_hit;

    always_comb begin
        wr_set  = bus_sel && bus_wr && (bus_addr == OFS_SET);
        wr_clr  = bus_sel && bus_wr && (bus_addr == OFS_CLR);
        wr_type = bus_sel && bus_wr && (bus_addr == OFS_TYPE);
        wr_hit  = wr_set || wr_clr || wr_type;
        cfg_d   = cfg_q;
        if (wr_set)  cfg_d.en    = cfg_q.en | bus_wdata;
        if (wr_clr)  cfg_d.en    = cfg_q.en & ~bus_wdata;
        if (wr_type) cfg_d.route = bus_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            unique case (bus_addr)
                OFS_ST0:          bus_rdata = st0;
                OFS_ST1:          bus_rdata = st1;
                OFS_TYPE:         bus_rdata = cfg_q.route;
                OFS_RAW:          bus_rdata = raw;
                OFS_SET, OFS_CLR: bus_rdata = cfg_q.en;
                default:          bus_rdata = '0;
            endcase
        end
    end

    assign cfg = cfg_q;

    assert_set_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_set |=> (cfg_q.en & $past(bus_wdata)) == $past(bus_wdata));
    assert_set_keep_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_set |=> (cfg_q.en & ~$past(bus_wdata)) == ($past(cfg_q.en) & ~$past(bus_wdata)));
    assert_clr_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr |=> (cfg_q.en & $past(bus_wdata)) == '0);
    assert_unmapped_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && !wr_hit) |=> $stable(cfg_q));
endmodule

// File: rtl/lvl_irq_route.sv
module lvl_irq_route
    import lvl_irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] raw,
    input  cfg_t            cfg,
    output logic [NSRC-1:0] st0,
    output logic [NSRC-1:0] st1,
    output outs_t           outs
);
    localparam logic [NSRC-1:0] SRC_MASK = {1'b0, {(NSRC-1){1'b1}}};

    outs_t outs_d, outs_q;
    logic  master;

    always_comb begin
        master      = cfg.en[GBIT];
        st0         = raw & cfg.en & ~cfg.route & SRC_MASK;
        st1         = raw & cfg.en &  cfg.route & SRC_MASK;
        outs_d.irq0 = master && (|st0);
        outs_d.irq1 = master && (|st1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) outs_q <= '0;
        else        outs_q <= outs_d;
    end

    assign outs = outs_q;

    assert_master_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.en[GBIT] |=> !outs_q.irq0 && !outs_q.irq1);
    assert_disjoint_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st0 & st1) == '0);
    assert_top_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !st0[GBIT] && !st1[GBIT]);
endmodule

// File: rtl/lvl_irq_ctrl.sv
module lvl_irq_ctrl
    import lvl_irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_sel,
    input  logic            bus_wr,
    input  logic [AW-1:0]   bus_addr,
    input  logic [NSRC-1:0] bus_wdata,
    output logic [NSRC-1:0] bus_rdata,
    input  logic [NSRC-1:0] src_irq,
    output logic            cpu_irq0,
    output logic            cpu_irq1
);
    logic [NSRC-1:0] raw_w, st0_w, st1_w;
    cfg_t            cfg_w;
    outs_t           outs_w;

    lvl_irq_sync #(.W(NSRC), .STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(src_irq), .raw_out(raw_w)
    );

    lvl_irq_regs u_regs (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .raw(raw_w),
        .st0(st0_w), .st1(st1_w), .cfg(cfg_w), .bus_rdata(bus_rdata)
    );

    lvl_irq_route u_route (
        .clk(clk), .rst_n(rst_n), .raw(raw_w), .cfg(cfg_w),
        .st0(st0_w), .st1(st1_w), .outs(outs_w)
    );

    assign cpu_irq0 = outs_w.irq0;
    assign cpu_irq1 = outs_w.irq1;

    assert_rise0_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_w.en[GBIT] && (|st0_w)) |=> cpu_irq0);
    assert_fall0_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_w.en[GBIT] && (|st0_w)) |=> !cpu_irq0);
    assert_rise1_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_w.en[GBIT] && (|st1_w)) |=> cpu_irq1);
endmodule

// File: tb/lvl_irq_ctrl_tb.sv
module lvl_irq_ctrl_tb_top;
    localparam time CLK_PERIOD = 10ns;
    localparam int  NVEC = 8;

    typedef struct packed {
        logic [31:0] src;
        logic [31:0] en;
        logic [31:0] route;
        logic        x0;
        logic        x1;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{32'h0000_0001, 32'h8000_0001, 32'h0000_0000, 1'b1, 1'b0},
        '{32'h0000_0002, 32'h8000_0002, 32'h0000_0002, 1'b0, 1'b1},
        '{32'h0000_0006, 32'h8000_0006, 32'h0000_0004, 1'b1, 1'b1},
        '{32'h0000_00F0, 32'h0000_00F0, 32'h0000_0000, 1'b0, 1'b0},
        '{32'hFFFF_FFFF, 32'h8000_0000, 32'h0000_0000, 1'b0, 1'b0},
        '{32'h8000_0000, 32'hFFFF_FFFF, 32'h0000_0000, 1'b0, 1'b0},
        '{32'h4000_0000, 32'hC000_0000, 32'hFFFF_FFFF, 1'b0, 1'b1},
        '{32'h0001_0000, 32'h8001_0000, 32'h0000_0000, 1'b1, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] src_irq = '0;
    logic        cpu_irq0, cpu_irq1;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lvl_irq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .src_irq(src_irq), .cpu_irq0(cpu_irq0), .cpu_irq1(cpu_irq1)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_sel = 1'b0; bus_addr = '0;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        logic [31:0] s0, s1;
        settle(3);
        rst_n = 1'b1;
        settle(1);

        // R1 reset state
        rd(8'h34, d); check("R1 mask", d, 32'h0);
        rd(8'h20, d); check("R1 route", d, 32'h0);
        check("R1 irq0", {31'b0, cpu_irq0}, 32'h0);
        check("R1 irq1", {31'b0, cpu_irq1}, 32'h0);

        // Table walk: R4 R5 R6 R7 R8 R11
        for (int i = 0; i < NVEC; i++) begin
            wr(8'h38, 32'hFFFF_FFFF);
            wr(8'h34, VECS[i].en);
            wr(8'h20, VECS[i].route);
            src_irq = VECS[i].src;
            settle(6);
            s0 = VECS[i].src & VECS[i].en & ~VECS[i].route & 32'h7FFF_FFFF;
            s1 = VECS[i].src & VECS[i].en &  VECS[i].route & 32'h7FFF_FFFF;
            rd(8'h38, d); check("R2 mask readback", d, VECS[i].en);
            rd(8'h20, d); check("R11 route readback", d, VECS[i].route);
            rd(8'h30, d); check("R8 raw", d, VECS[i].src);
            rd(8'h00, d); check("R5 status0", d, s0);
            rd(8'h04, d); check("R6 status1", d, s1);
            check("R4 R7 irq0", {31'b0, cpu_irq0}, {31'b0, VECS[i].x0});
            check("R4 R7 irq1", {31'b0, cpu_irq1}, {31'b0, VECS[i].x1});
        end

        // R2 and R3: set and clear act only on bits written as 1
        wr(8'h38, 32'hFFFF_FFFF);
        rd(8'h34, d); check("R3 clear all", d, 32'h0);
        wr(8'h34, 32'h0000_0001);
        wr(8'h34, 32'h0000_0004);
        rd(8'h34, d); check("R2 set keeps others", d, 32'h0000_0005);
        wr(8'h34, 32'h8000_0F00);
        wr(8'h38, 32'h0000_0104);
        rd(8'h34, d); check("R3 partial clear", d, 32'h8000_0E01);

        // R10 unmapped offsets
        wr(8'h20, 32'h0000_00AA);
        wr(8'h10, 32'hFFFF_FFFF);
        wr(8'h3C, 32'hFFFF_FFFF);
        rd(8'h34, d); check("R10 mask unchanged", d, 32'h8000_0E01);
        rd(8'h20, d); check("R10 route unchanged", d, 32'h0000_00AA);
        rd(8'h10, d); check("R10 unmapped read", d, 32'h0);

        // R8/R7 latency, edge by edge
        wr(8'h20, 32'h0);
        wr(8'h38, 32'hFFFF_FFFF);
        wr(8'h34, 32'h8000_0008);
        src_irq = 32'h0;
        settle(5);
        src_irq = 32'h0000_0008;
        settle(2);
        rd(8'h30, d); check("R8 raw after 2 edges", d, 32'h0);
        settle(1);
        rd(8'h30, d); check("R8 raw after 3 edges", d, 32'h0000_0008);
        check("R7 irq0 not yet", {31'b0, cpu_irq0}, 32'h0);
        settle(1);
        check("R7 irq0 after 4 edges", {31'b0, cpu_irq0}, 32'h1);

        // R9 level persistence and release by masking
        settle(10);
        rd(8'h00, d); check("R9 status held", d, 32'h0000_0008);
        check("R9 irq0 held", {31'b0, cpu_irq0}, 32'h1);
        wr(8'h38, 32'h0000_0008);
        rd(8'h00, d); check("R9 masked status", d, 32'h0);
        settle(1);
        check("R9 irq0 masked", {31'b0, cpu_irq0}, 32'h0);
        wr(8'h34, 32'h0000_0008);
        settle(2);
        check("R9 irq0 re-enabled", {31'b0, cpu_irq0}, 32'h1);
        src_irq = 32'h0;
        settle(5);
        rd(8'h00, d); check("R9 source low status", d, 32'h0);
        check("R9 source low irq0", {31'b0, cpu_irq0}, 32'h0);

        // R4 master switch dropped while source pending
        src_irq = 32'h0000_0008;
        settle(5);
        wr(8'h38, 32'h8000_0000);
        settle(1);
        check("R4 master off irq0", {31'b0, cpu_irq0}, 32'h0);

        // R1 reset again clears configuration
        rst_n = 1'b0;
        settle(1);
        rst_n = 1'b1;
        settle(1);
        rd(8'h34, d); check("R1 mask after reset", d, 32'h0);
        check("R1 irq0 after reset", {31'b0, cpu_irq0}, 32'h0);

        finish_run();
    end
endmodule